// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block gives a host access to banks of 8-bit control registers through only two byte-wide I/O locations. The lower location holds a register number (the index port) and the upper location moves data to or from the register that number names (the data port). The registers stay locked until the host writes a two-byte key to the index port. Once the block is unlocked, the host picks one of several logical devices through a selector register. It then reads or writes that device's registers by writing an index and accessing the data port. A single exit byte locks the block again.

Register numbers below 0x30 form a shared space. The only one implemented there is the device selector at 0x07. Numbers from 0x30 upward belong to whichever logical device is selected. For those numbers the block raises a write enable toward that one device only, and it returns that device's read data. The default build has nine devices, numbered 0 to 8, and a watchdog would normally sit in device 8.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the block is locked, the index register is 0x00 and device 0 is selected. After unlocking, a data-port read with no index write returns 0x00, and the selector at 0x07 reads 0x00.
- R2: Two consecutive index-port writes of 0x55 (busAddr=0) unlock the block.
- R3: While the block is unlocked, an index-port write of 0xAA locks it. The index register keeps its previous value.
- R4: While the block is locked, a data-port read returns 0xFF, a data-port write raises no devWe bit, and an index-port write does not change the index register.
- R5: After the first 0x55, any write other than a second 0x55 to the index port returns the key sequence to its start. This includes a data-port write.
- R6: While the block is unlocked, writing 0x07 to the index port and then a value to the data port selects that logical device. A data-port read at index 0x07 returns the selected device number.
- R7: While the block is unlocked and the index is 0x30 or above, a data-port write raises devWe only for the selected device, in the same cycle as busWr. During that cycle it presents regAddr equal to the index and regWdata equal to the written byte.
- R8: While the block is unlocked and the index is 0x30 or above, a data-port read returns the selected device's devRdata byte, taken from bits [8*d+7:8*d]. If the selected number is NUM_DEV or greater, the read returns 0xFF and writes raise no devWe bit.
- R9: busRdata is registered. It takes the new value on the clock edge that samples busRd, and it holds that value until the next read.
- R10: Index values below 0x30 other than 0x07 read 0x00, and data-port writes to them raise no devWe bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 1 | 0 = index port, 1 = data port |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, ignored when busWr is high |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Registered host read data |
| regAddr | output | 8 | Current index toward the devices |
| regWdata | output | 8 | Write data toward the devices |
| devWe | output | NUM_DEV | Per-device register write enable |
| devRdata | input | NUM_DEV*8 | Read data from each device at regAddr |

## Verification
Directed sequences cover the correct key and two broken keys: one broken by a stray index byte and one broken by a data-port write. Together they show that the unlock needs two 0x55 bytes with nothing between them. Locked index writes are followed by an unlock and a readback, which shows whether the index register was kept. The bench selects device 0, device 8 and an out-of-range device, so that routing to the right device can be told apart from broadcasting or from a default. Random mixes of index writes, which favour the key, exit and selector values, data writes and reads are then checked against a bench model of the lock state, the index and the selector.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam logic [7:0] KEY_BYTE  = 8'h55;
  localparam logic [7:0] EXIT_BYTE = 8'hAA;
  localparam logic [7:0] SEL_IDX   = 8'h07;
  localparam logic [7:0] DEV_BASE  = 8'h30;

  typedef enum logic [1:0] {
    ST_LOCKED  = 2'd0,
    ST_KEYHALF = 2'd1,
    ST_OPEN    = 2'd2
  } unlockState_t;

  typedef struct packed {
    logic idxLoad;
    logic dataWrite;
    logic dataRead;
    logic cfgOpen;
  } cfgStrobe_t;
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output cfgStrobe_t strobe
);
  unlockState_t state, stateNext;
  logic idxWr, dataWr;

  assign idxWr  = busWr & ~busAddr;
  assign dataWr = busWr & busAddr;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_LOCKED:  if (idxWr && busWdata == KEY_BYTE) stateNext = ST_KEYHALF;
      ST_KEYHALF: begin
        if (idxWr) stateNext = (busWdata == KEY_BYTE) ? ST_OPEN : ST_LOCKED;
        else if (dataWr) stateNext = ST_LOCKED;
      end
      ST_OPEN:    if (idxWr && busWdata == EXIT_BYTE) stateNext = ST_LOCKED;
      default:    stateNext = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.cfgOpen   = (state == ST_OPEN);
    strobe.idxLoad   = strobe.cfgOpen & idxWr & (busWdata != EXIT_BYTE);
    strobe.dataWrite = strobe.cfgOpen & dataWr;
    strobe.dataRead  = busRd & ~busWr;
  end
endmodule

// File: rtl/cfgport_dp.sv
module cfgport_dp
  import cfgport_pkg::*;
#(
  parameter int NUM_DEV = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           strobe,
  input  logic                 busAddr,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  output logic [7:0]           regAddr,
  output logic [7:0]           regWdata,
  output logic [NUM_DEV-1:0]   devWe,
  input  logic [NUM_DEV*8-1:0] devRdata
);
  logic [7:0] indexReg, devSel, devMux, readVal;
  logic       devSpace, selValid, devWrite;

  assign devSpace = (indexReg >= DEV_BASE);
  assign devWrite = strobe.dataWrite & devSpace & selValid;
  assign regAddr  = indexReg;
  assign regWdata = busWdata;

  always_comb begin
    devMux   = 8'hFF;
    selValid = 1'b0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (devSel == 8'(d)) begin
        devMux   = devRdata[d*8 +: 8];
        selValid = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_we
    assign devWe[g] = devWrite & (devSel == 8'(g));
  end

  always_comb begin
    if (!strobe.cfgOpen)          readVal = 8'hFF;
    else if (indexReg == SEL_IDX) readVal = devSel;
    else if (!devSpace)           readVal = 8'h00;
    else                          readVal = devMux;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= 8'h00;
      devSel   <= 8'h00;
      busRdata <= 8'h00;
    end else begin
      if (strobe.idxLoad) indexReg <= busWdata;
      if (strobe.dataWrite && indexReg == SEL_IDX) devSel <= busWdata;
      if (strobe.dataRead && busAddr) busRdata <= readVal;
      else if (strobe.dataRead)       busRdata <= indexReg;
    end
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgport_pkg::*;
#(
  parameter int NUM_DEV = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  output logic [7:0]           regAddr,
  output logic [7:0]           regWdata,
  output logic [NUM_DEV-1:0]   devWe,
  input  logic [NUM_DEV*8-1:0] devRdata
);
  cfgStrobe_t strobe;
  logic       isOpen;

  assign isOpen = strobe.cfgOpen;

  cfgport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .strobe(strobe)
  );

  cfgport_dp #(.NUM_DEV(NUM_DEV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .regAddr(regAddr),
    .regWdata(regWdata), .devWe(devWe), .devRdata(devRdata)
  );
endmodule

// File: rtl/cfg_index_chk.sv
module cfg_index_chk #(
  parameter int NUM_DEV = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               busAddr,
  input logic               busWr,
  input logic               busRd,
  input logic [7:0]         busWdata,
  input logic [7:0]         busRdata,
  input logic [NUM_DEV-1:0] devWe,
  input logic               isOpen
);
  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!isOpen && busRd && !busWr && busAddr) |=> (busRdata == 8'hFF));

  p_locked_nowe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !isOpen |-> (devWe == '0));

  p_single_dev_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devWe));

  p_we_needs_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (devWe != '0) |-> (busWr && busAddr));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && !busWr) |=> $stable(busRdata));

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isOpen) |-> $past(busWr && !busAddr && busWdata == 8'h55));

  p_exit_locks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && busWr && !busAddr && busWdata == 8'hAA) |=> !isOpen);
endmodule

bind cfg_index_port cfg_index_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busRdata(busRdata), .devWe(devWe), .isOpen(isOpen)
);

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;
  localparam int NUM_DEV = 9;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0]           busWdata = 8'h00;
  logic [7:0]           busRdata, regAddr, regWdata;
  logic [NUM_DEV-1:0]   devWe;
  logic [NUM_DEV*8-1:0] devRdata;

  int total = 0;
  int bad = 0;

  // bench model of the block state
  int         mState = 0;  // 0 locked, 1 half key, 2 open
  logic [7:0] mIdx = 8'h00;
  logic [7:0] mSel = 8'h00;
  logic [7:0] lastRead = 8'h00;

  always #4 clk = ~clk;

  cfg_index_port #(.NUM_DEV(NUM_DEV)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .regAddr(regAddr),
    .regWdata(regWdata), .devWe(devWe), .devRdata(devRdata)
  );

  function automatic logic [7:0] devPattern(int d, logic [7:0] a);
    return {4'(d), a[3:0]} ^ 8'h5A;
  endfunction

  always_comb
    for (int d = 0; d < NUM_DEV; d++) devRdata[d*8 +: 8] = devPattern(d, regAddr);

  function automatic logic [7:0] expRead();
    if (mState != 2) return 8'hFF;
    if (mIdx == 8'h07) return mSel;
    if (mIdx < 8'h30) return 8'h00;
    if (mSel < 8'(NUM_DEV)) return devPattern(int'(mSel), mIdx);
    return 8'hFF;
  endfunction

  function automatic logic [NUM_DEV-1:0] expWe();
    if (mState == 2 && mIdx >= 8'h30 && mSel < 8'(NUM_DEV))
      return NUM_DEV'(1) << mSel;
    return '0;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic writeIdx(logic [7:0] v, string tag);
    @(negedge clk);
    busAddr = 1'b0; busWr = 1'b1; busWdata = v;
    #1 check(tag, 16'(devWe), 16'h0);
    @(posedge clk); #1 busWr = 1'b0;
    case (mState)
      0: if (v == 8'h55) mState = 1;
      1: mState = (v == 8'h55) ? 2 : 0;
      default: if (v == 8'hAA) mState = 0; else mIdx = v;
    endcase
  endtask

  task automatic writeData(logic [7:0] v, string tag);
    logic [NUM_DEV-1:0] e;
    e = expWe();
    @(negedge clk);
    busAddr = 1'b1; busWr = 1'b1; busWdata = v;
    #1 check(tag, 16'(devWe), 16'(e));
    if (e != '0) check({tag, " addr/data"}, {regAddr, regWdata}, {mIdx, v});
    @(posedge clk); #1 busWr = 1'b0;
    if (mState == 1) mState = 0;
    else if (mState == 2 && mIdx == 8'h07) mSel = v;
  endtask

  task automatic readData(string tag);
    logic [7:0] e;
    e = expRead();
    @(negedge clk);
    busAddr = 1'b1; busRd = 1'b1;
    @(posedge clk); #1 busRd = 1'b0;
    @(negedge clk);
    check(tag, 16'(busRdata), 16'(e));
    lastRead = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state and locked behaviour
    readData("R1 R4 locked read after reset");
    writeData(8'h12, "R4 locked data write");
    writeIdx(8'h55, "R2 key byte 1");
    writeIdx(8'h55, "R2 key byte 2");
    readData("R1 index cleared by reset");
    writeIdx(8'h07, "R6 index selector");
    readData("R1 device 0 after reset");
    writeIdx(8'h40, "R7 index device reg");
    writeData(8'h3C, "R1 R7 write reaches device 0");

    // device 8 selection and routing
    writeIdx(8'h07, "R6 index selector");
    writeData(8'h08, "R6 select device 8");
    readData("R6 selector readback");
    writeIdx(8'h31, "R7 index device reg");
    writeData(8'hA5, "R7 write only device 8");
    readData("R8 device 8 read data");

    // shared space other than the selector
    writeIdx(8'h20, "R10 index shared reg");
    writeData(8'h77, "R10 shared write no enable");
    readData("R10 shared read zero");

    // out-of-range device
    writeIdx(8'h07, "R6 index selector");
    writeData(8'h0C, "R6 select device 12");
    writeIdx(8'h35, "R8 index device reg");
    writeData(8'h11, "R8 out-of-range write");
    readData("R8 out-of-range read");

    // lock keeps the index, locked index writes ignored
    writeIdx(8'h07, "R6 index selector");
    writeIdx(8'hAA, "R3 exit byte");
    readData("R3 read after lock");
    writeIdx(8'h40, "R4 locked index write");
    writeIdx(8'h55, "R2 key byte 1");
    writeIdx(8'h55, "R2 key byte 2");
    readData("R3 R4 index kept across lock");

    // broken keys
    writeIdx(8'hAA, "R3 exit byte");
    writeIdx(8'h55, "R5 key byte 1");
    writeIdx(8'h10, "R5 stray index byte");
    writeIdx(8'h55, "R5 restart key");
    readData("R5 still locked after broken key");
    writeIdx(8'h55, "R2 key completes");
    readData("R2 unlocked after restart");
    writeIdx(8'hAA, "R3 exit byte");
    writeIdx(8'h55, "R5 key byte 1");
    writeData(8'h00, "R5 data write breaks key");
    writeIdx(8'h55, "R5 restart key");
    readData("R5 locked after data write");
    writeIdx(8'h55, "R2 key completes");

    // read data holds between reads
    writeIdx(8'h07, "R9 index change");
    repeat (4) @(negedge clk);
    check("R9 read data held", 16'(busRdata), 16'(lastRead));

    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k < 3) begin
        logic [7:0] v;
        case ($urandom_range(0, 4))
          0, 1: v = 8'h55;
          2: v = 8'hAA;
          3: v = 8'h07;
          default: v = 8'($urandom_range(0, 255));
        endcase
        writeIdx(v, "R4 random index write");
      end else if (k < 6) begin
        logic [7:0] v;
        v = (mIdx == 8'h07) ? 8'($urandom_range(0, 11)) : 8'($urandom_range(0, 255));
        writeData(v, "R7 random data write");
      end else begin
        readData("R8 random read");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule